// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block sits between a host and a battery-backed static memory array and decides, cycle by cycle, whether the host may reach the array. Three comparator flags arrive already digitised: supply above the operating level, supply above the write-lock level, and supply above the cell switchover level. From these the block runs a five-state sequence (fresh and never powered, running on the cell, locked, recovering, active) and gates the host's upper-byte enable, lower-byte enable and write strobe. While the array is not active, it also forces the data drivers to high impedance.

A one-shot "first power applied" event arms the backup cell. Until that event, losing the supply returns the block to the fresh state and never selects the cell. Once armed, a supply collapse selects the cell until the supply passes the switchover level again. After every return to full supply the enables are held off for a programmable number of clock cycles. The timer starts again from zero if the supply dips during that window. A write the host has already started when the lock-out begins is cut off at once. After access returns, the write strobe stays blocked until the host has released it once.

Top module: `pwr_guard_top`

## Requirements
- R1: After reset, ceu_n_o, cel_n_o and we_n_o are 1, hiz_o is 1, bat_sel_o is 0 and cell_armed_o is 0.
- R2: In the active state each gated chip-enable equals its host input, hiz_o is 0, and we_n_o equals we_n_i once the write strobe is ready (see R8).
- R3: Outside the active state, ceu_n_o, cel_n_o and we_n_o are 1 and hiz_o is 1, whatever the host inputs do.
- R4: Each comparator flag passes through two synchronizing flops. When the operating flag rises while the block is locked, with the lock and switchover flags high, the block first grants access on the clock edge numbered REC_CYCLES+3 after the flag change, and not before.
- R5: If the operating flag falls during recovery, the block returns to the locked state. A later rise starts a fresh full REC_CYCLES window.
- R6: In the active state, with the operating flag low and the lock flag high, we_n_o is forced to 1 while reads (chip-enables, hiz_o = 0) still pass.
- R7: When the lock flag falls in the active state, we_n_o goes to 1 by the second clock edge after the input change, cutting off any write in progress. The block enters the locked state on the next edge.
- R8: On entering the active state, we_n_o stays 1 until we_n_i has been sampled at 1 on a clock edge in the active state.
- R9: With the cell armed, a fall of the switchover flag selects the cell (bat_sel_o = 1). A rise deselects it (bat_sel_o = 0) and enters the locked state.
- R10: While the cell is unarmed, bat_sel_o never becomes 1, even when the switchover flag falls.
- R11: A one-cycle pulse on first_pwr_i sets cell_armed_o. It stays 1 until reset.
- R12: From the cell-powered state, access returns only through the locked and recovering states, with the full recovery delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| v_run_i | input | 1 | Supply above operating level (asynchronous) |
| v_lock_i | input | 1 | Supply above write-lock level (asynchronous) |
| v_swap_i | input | 1 | Supply above cell switchover level (asynchronous) |
| first_pwr_i | input | 1 | First-power-applied event, one-cycle pulse |
| ceu_n_i | input | 1 | Host upper-byte enable, active low |
| cel_n_i | input | 1 | Host lower-byte enable, active low |
| we_n_i | input | 1 | Host write strobe, active low |
| ceu_n_o | output | 1 | Gated upper-byte enable, active low |
| cel_n_o | output | 1 | Gated lower-byte enable, active low |
| we_n_o | output | 1 | Gated write strobe, active low |
| hiz_o | output | 1 | Force data outputs to high impedance |
| bat_sel_o | output | 1 | Select backup cell as array supply |
| cell_armed_o | output | 1 | Backup cell connection armed |

## Verification
The bench builds the block with REC_CYCLES set to 8 instead of the default of thousands of cycles. This keeps the exact edge on which access returns close enough to check on both sides of the boundary, and it lets a supply dip be placed in the middle of a recovery window. Each flag is toggled on its own, so the write cut by the lock flag can be told apart from the read-only band set by the operating flag. The armed and unarmed supply collapses are both run.

// File: rtl/pwr_guard_pkg.sv
// Shared types for the power-fail supervisor.
package pwr_guard_pkg;

    // Sequencer states, ordered from least to most capable.
    typedef enum logic [2:0] {
        PG_FRESH  = 3'd0,
        PG_BATT   = 3'd1,
        PG_LOCK   = 3'd2,
        PG_RECOV  = 3'd3,
        PG_ACTIVE = 3'd4
    } pg_state_t;

    // Bit positions of the comparator flags in the synchronized vector.
    localparam int unsigned FLAG_RUN  = 0;
    localparam int unsigned FLAG_LOCK = 1;
    localparam int unsigned FLAG_SWAP = 2;
    localparam int unsigned NUM_FLAGS = 3;

endpackage

// File: rtl/pwr_flag_sync.sv
// Multi-stage synchronizer for a vector of slow asynchronous level flags.
// Assumes each flag is a level and holds for several clocks; no pulse capture.
module pwr_flag_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;

            // Shift the raw flag through the flop chain; reset reads as no supply.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[STAGES-2:0], async_i[b]};
                end
            end

            assign sync_o[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pwr_seq_fsm.sv
// Supply sequencer: tracks power state from synchronized flags, runs the
// recovery timer and holds the cell-arming latch.
// Assumes flags are already synchronous and that a higher flag implies the lower ones.
module pwr_seq_fsm
    import pwr_guard_pkg::*;
#(
    parameter int unsigned REC_CYCLES = 25000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_s,
    input  logic      lock_s,
    input  logic      swap_s,
    input  logic      first_pwr_i,
    output pg_state_t state_o,
    output logic      armed_o,
    output logic      bat_sel_o
);

    localparam int unsigned CW = $clog2(REC_CYCLES + 1) + 1;
    localparam logic [CW-1:0] LAST = CW'(REC_CYCLES - 1);

    pg_state_t      state_q, state_d;
    logic [CW-1:0]  rec_cnt;
    logic           armed_q;
    logic           rec_done;
    pg_state_t      drop_tgt;

    assign rec_done = (rec_cnt == LAST);
    // Loss of supply falls back to the cell only once it has been armed.
    assign drop_tgt = armed_q ? PG_BATT : PG_FRESH;

    // Next-state selection; lower-threshold losses take priority.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_FRESH, PG_BATT: begin
                if (swap_s) state_d = PG_LOCK;
            end
            PG_LOCK: begin
                if (!swap_s)               state_d = drop_tgt;
                else if (run_s && lock_s)  state_d = PG_RECOV;
            end
            PG_RECOV: begin
                if (!swap_s)               state_d = drop_tgt;
                else if (!lock_s || !run_s) state_d = PG_LOCK;
                else if (rec_done)         state_d = PG_ACTIVE;
            end
            PG_ACTIVE: begin
                if (!swap_s)      state_d = drop_tgt;
                else if (!lock_s) state_d = PG_LOCK;
            end
            default: state_d = PG_FRESH;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PG_FRESH;
        else        state_q <= state_d;
    end

    // Recovery timer: counts only while recovering, cleared in every other state.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rec_cnt <= '0;
        else if (state_q == PG_RECOV) rec_cnt <= rec_cnt + CW'(1);
        else                         rec_cnt <= '0;
    end

    // Cell-arming latch: set by the first power-up event, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          armed_q <= 1'b0;
        else if (first_pwr_i) armed_q <= 1'b1;
    end

    assign state_o   = state_q;
    assign armed_o   = armed_q;
    assign bat_sel_o = (state_q == PG_BATT);

endmodule

// File: rtl/pwr_access_gate.sv
// Host access gate: passes chip-enables and write strobe only when the
// sequencer is active, blocks writes below the operating or lock level,
// and waits for the strobe to be released once before honouring writes.
module pwr_access_gate
    import pwr_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pg_state_t state_i,
    input  logic      run_s,
    input  logic      lock_s,
    input  logic      ceu_n_i,
    input  logic      cel_n_i,
    input  logic      we_n_i,
    output logic      ceu_n_o,
    output logic      cel_n_o,
    output logic      we_n_o,
    output logic      hiz_o
);

    logic active;
    logic we_ready;

    assign active = (state_i == PG_ACTIVE);

    // Write-strobe readiness: cleared off the active state, set once the host strobe is seen high.
    always_ff @(posedge clk) begin
        if (!rst_n)              we_ready <= 1'b0;
        else if (!active)        we_ready <= 1'b0;
        else if (we_n_i)         we_ready <= 1'b1;
    end

    // Output gating; a falling lock or run flag cuts the strobe without waiting for the state.
    always_comb begin
        ceu_n_o = ceu_n_i | ~active;
        cel_n_o = cel_n_i | ~active;
        we_n_o  = we_n_i | ~active | ~we_ready | ~run_s | ~lock_s;
        hiz_o   = ~active;
    end

endmodule

// File: rtl/pwr_guard_top.sv
// Power-fail write-protect supervisor top: synchronizes the comparator flags,
// sequences supply states and gates host memory access.
// Assumes comparator flags are glitch-filtered levels and first_pwr_i is a synchronous pulse.
module pwr_guard_top
    import pwr_guard_pkg::*;
#(
    parameter int unsigned REC_CYCLES  = 25000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic v_run_i,
    input  logic v_lock_i,
    input  logic v_swap_i,
    input  logic first_pwr_i,
    input  logic ceu_n_i,
    input  logic cel_n_i,
    input  logic we_n_i,
    output logic ceu_n_o,
    output logic cel_n_o,
    output logic we_n_o,
    output logic hiz_o,
    output logic bat_sel_o,
    output logic cell_armed_o
);

    logic [NUM_FLAGS-1:0] flags_raw, flags_s;
    logic                 run_s, lock_s, swap_s;
    pg_state_t            fsm_state;

    assign flags_raw[FLAG_RUN]  = v_run_i;
    assign flags_raw[FLAG_LOCK] = v_lock_i;
    assign flags_raw[FLAG_SWAP] = v_swap_i;

    pwr_flag_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (flags_raw),
        .sync_o  (flags_s)
    );

    assign run_s  = flags_s[FLAG_RUN];
    assign lock_s = flags_s[FLAG_LOCK];
    assign swap_s = flags_s[FLAG_SWAP];

    pwr_seq_fsm #(.REC_CYCLES(REC_CYCLES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_s       (run_s),
        .lock_s      (lock_s),
        .swap_s      (swap_s),
        .first_pwr_i (first_pwr_i),
        .state_o     (fsm_state),
        .armed_o     (cell_armed_o),
        .bat_sel_o   (bat_sel_o)
    );

    pwr_access_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_i (fsm_state),
        .run_s   (run_s),
        .lock_s  (lock_s),
        .ceu_n_i (ceu_n_i),
        .cel_n_i (cel_n_i),
        .we_n_i  (we_n_i),
        .ceu_n_o (ceu_n_o),
        .cel_n_o (cel_n_o),
        .we_n_o  (we_n_o),
        .hiz_o   (hiz_o)
    );

endmodule

// File: rtl/pwr_guard_chk.sv
// Property checker for the supervisor, attached to the top by bind.
// Observes ports plus the synchronized flags and sequencer state.
module pwr_guard_chk
    import pwr_guard_pkg::*;
#(
    parameter int unsigned REC_CYCLES = 25000
) (
    input logic      clk,
    input logic      rst_n,
    input pg_state_t state,
    input logic      run_s,
    input logic      lock_s,
    input logic      swap_s,
    input logic      ceu_n_o,
    input logic      cel_n_o,
    input logic      we_n_o,
    input logic      hiz_o,
    input logic      bat_sel_o,
    input logic      cell_armed_o
);

    localparam int unsigned LW = $clog2(REC_CYCLES + 2) + 1;
    logic [LW-1:0] rec_len;

    // Length of the current recovery stay, counted independently of the timer.
    always_ff @(posedge clk) begin
        if (!rst_n)                rec_len <= '0;
        else if (state == PG_RECOV) rec_len <= rec_len + LW'(1);
        else                       rec_len <= '0;
    end

    assert_blocked_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hiz_o |-> (ceu_n_o && cel_n_o && we_n_o));

    assert_rec_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PG_ACTIVE && $past(state) == PG_RECOV) |-> (rec_len == LW'(REC_CYCLES)));

    assert_rec_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PG_RECOV && swap_s && !run_s) |=> (state == PG_LOCK));

    assert_write_needs_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_o |-> (run_s && lock_s));

    assert_lock_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PG_ACTIVE && swap_s && !lock_s) |=> hiz_o);

    assert_cell_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bat_sel_o && swap_s) |=> !bat_sel_o);

    assert_cell_needs_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bat_sel_o |-> cell_armed_o);

    assert_arm_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cell_armed_o |=> cell_armed_o);

    assert_batt_path_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PG_BATT) |-> (state == PG_BATT || state == PG_LOCK));

endmodule

bind pwr_guard_top pwr_guard_chk #(.REC_CYCLES(REC_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (fsm_state),
    .run_s        (run_s),
    .lock_s       (lock_s),
    .swap_s       (swap_s),
    .ceu_n_o      (ceu_n_o),
    .cel_n_o      (cel_n_o),
    .we_n_o       (we_n_o),
    .hiz_o        (hiz_o),
    .bat_sel_o    (bat_sel_o),
    .cell_armed_o (cell_armed_o)
);

// File: tb/tb_pwr_guard_top.sv
// Directed bench for the power-fail supervisor; outputs are sampled on falling edges.
module tb_pwr_guard_top;

    localparam int unsigned REC = 8;

    logic clk = 1'b0;
    logic rst_n, v_run_i, v_lock_i, v_swap_i, first_pwr_i;
    logic ceu_n_i, cel_n_i, we_n_i;
    logic ceu_n_o, cel_n_o, we_n_o, hiz_o, bat_sel_o, cell_armed_o;
    int   n_chk = 0;
    int   n_fail = 0;

    always #4 clk = ~clk;

    pwr_guard_top #(.REC_CYCLES(REC)) dut (
        .clk(clk), .rst_n(rst_n), .v_run_i(v_run_i), .v_lock_i(v_lock_i),
        .v_swap_i(v_swap_i), .first_pwr_i(first_pwr_i), .ceu_n_i(ceu_n_i),
        .cel_n_i(cel_n_i), .we_n_i(we_n_i), .ceu_n_o(ceu_n_o), .cel_n_o(cel_n_o),
        .we_n_o(we_n_o), .hiz_o(hiz_o), .bat_sel_o(bat_sel_o), .cell_armed_o(cell_armed_o)
    );

    // Output vector: {ceu_n_o, cel_n_o, we_n_o, hiz_o, bat_sel_o, cell_armed_o}
    function automatic logic [5:0] outs();
        return {ceu_n_o, cel_n_o, we_n_o, hiz_o, bat_sel_o, cell_armed_o};
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic host(input logic u, input logic l, input logic w);
        ceu_n_i = u; cel_n_i = l; we_n_i = w;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; v_run_i = 0; v_lock_i = 0; v_swap_i = 0; first_pwr_i = 0;
        host(1, 1, 1);
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R1 reset outputs", outs(), 6'b111100);
    endtask

    task automatic t_unarmed_loss();
        host(0, 0, 0);
        step(2);
        check("R3 fresh ignores host", outs(), 6'b111100);
        v_swap_i = 1; step(4);
        v_swap_i = 0; step(4);
        check("R10 unarmed loss no cell", outs(), 6'b111100);
    endtask

    task automatic t_powerup();
        v_swap_i = 1; v_lock_i = 1; step(4);
        first_pwr_i = 1; step(1); first_pwr_i = 0; step(1);
        check("R11 arm pulse", outs(), 6'b111101);
        host(0, 0, 0);
        v_run_i = 1;
        step(2 + REC);
        check("R4 still held before delay", outs(), 6'b111101);
        step(1);
        check("R4 R8 access opens, strobe held", outs(), 6'b001001);
        we_n_i = 1; step(1);
        we_n_i = 0; step(1);
        check("R2 write passes", outs(), 6'b000001);
        ceu_n_i = 1; step(1);
        check("R2 lower byte only", outs(), 6'b100001);
        ceu_n_i = 0;
    endtask

    task automatic t_run_band();
        v_run_i = 0; step(3);
        check("R6 reads only below operating", outs(), 6'b001001);
        v_run_i = 1; step(3);
        check("R6 writes back above operating", outs(), 6'b000001);
    endtask

    task automatic t_lock_cut();
        v_lock_i = 0; step(2);
        check("R7 write cut by lock flag", outs(), 6'b001001);
        step(1);
        check("R7 locked state", outs(), 6'b111101);
    endtask

    task automatic t_dip_restart();
        v_run_i = 0; v_lock_i = 1; step(4);
        v_run_i = 1; step(6);
        v_run_i = 0; step(4);
        check("R5 dip returns to locked", outs(), 6'b111101);
        v_run_i = 1;
        step(2 + REC);
        check("R5 full window after dip", outs(), 6'b111101);
        step(1);
        check("R5 R8 open after fresh window", outs(), 6'b001001);
    endtask

    task automatic t_cell_cycle();
        v_run_i = 0; v_lock_i = 0; v_swap_i = 0; step(4);
        check("R9 cell selected", outs(), 6'b111111);
        host(1, 0, 1); step(1); host(0, 1, 0); step(1);
        check("R3 cell state ignores host", outs(), 6'b111111);
        host(0, 0, 0);
        v_swap_i = 1; step(4);
        check("R9 cell released", outs(), 6'b111101);
        v_lock_i = 1; v_run_i = 1;
        step(2 + REC);
        check("R12 held through recovery", outs(), 6'b111101);
        step(1);
        check("R12 access after recovery", outs(), 6'b001001);
    endtask

    task automatic t_rearm_reset();
        rst_n = 1'b0; step(2);
        rst_n = 1'b1; v_run_i = 0; v_lock_i = 0; v_swap_i = 0; step(1);
        check("R11 armed cleared by reset", outs(), 6'b111100);
    endtask

    initial begin
        t_reset();
        t_unarmed_loss();
        t_powerup();
        t_run_band();
        t_lock_cut();
        t_dip_restart();
        t_cell_cycle();
        t_rearm_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule